// File: doc/BRIEF.md
# Phase-Accumulator Sine Oscillator

This block is a numerically controlled oscillator. A 32-bit phase register advances by a programmable step on every enabled clock. The sum of that register and a separate phase offset is reduced to its top 12 bits, which select a point on a 4096-step circle. A table holding only the first quarter of a sine wave turns that point into a signed 16-bit sample. The other three quarters come from mirroring the table index and negating the result.

The output frequency is the step times the clock rate divided by 2^32. A step of 1 gives the finest tuning increment. Changing the step keeps the phase continuous, because the phase register is never disturbed. Changing the offset moves the output phase at once, by that fraction of a cycle, and leaves the register untouched. A one-cycle pulse marks every wrap of the phase register, which is one completed output cycle.

Top module: `nco_sine`

## Requirements
- R1: A synchronous reset, active high, clears the phase register to zero and drives sample to 0, sample_valid to 0 and wrap to 0.
- R2: On each rising edge with en=1 the phase register becomes (register + tune_word) mod 2^32. With en=0 the register holds and wrap stays 0.
- R3: The lookup phase p is bits 31:20 of (register + phase_ofs) mod 2^32. Bits 19:0 never affect the lookup, but they still carry into the upper bits as the register accumulates.
- R4: Let q = p[11:10] and k = p[9:0]. Let f = 1024-k when q[0]=1 and f = k otherwise. Then m = round(32767*sin(pi/2*f/1024)), and sample = -m when q[1]=1 and +m otherwise. Phase steps 0, 1024, 2048 and 3072 give 0, +32767, 0 and -32767. The value -32768 never appears.
- R5: The sample visible after clock edge k+2 is the R4 amplitude of the phase register value held after edge k, combined with the phase_ofs applied during the following cycle. With phase_ofs=0, the first valid sample after reset is 0.
- R6: After reset is released, sample_valid is 0 after the first edge, becomes 1 after the second edge, and stays 1 until the next reset.
- R7: wrap is 1 for exactly the cycle that follows an edge whose register addition carries out of bit 31, and 0 otherwise.
- R8: phase_ofs never changes the phase register. Removing an offset returns the output to the track it would have had without the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the phase register when 1 |
| tune_word | input | 32 | Phase step added on each enabled edge |
| phase_ofs | input | 32 | Offset added to the phase before the lookup |
| sample | output | 16 | Signed sine amplitude |
| sample_valid | output | 1 | Pipeline has filled since reset |
| wrap | output | 1 | One-cycle pulse on each register wrap |

## Verification
The hardest cases to reach are the exact quarter-wave boundaries: the odd quadrants at index 0, where the mirrored index points one step past the stored quarter. To reach them, the phase register is parked at zero with en low, and phase_offset alone is stepped onto each boundary. Those offsets also carry junk in the low 20 bits, so that any leak of the dropped bits into the lookup would show up. Running sequences with half-step tuning, an all-ones tuning word (one wrap on every edge) and offsets switched on and off during a run are compared cycle by cycle against an independent model of the register and the two pipeline stages.

// File: rtl/nco_sine.sv
module nco_sine #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 12,
  parameter int AMP_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ACC_W-1:0]        tune_word,
  input  logic [ACC_W-1:0]        phase_ofs,
  output logic signed [AMP_W-1:0] sample,
  output logic                    sample_valid,
  output logic                    wrap
);
  localparam int QW = ADDR_W - 2;
  localparam int QN = 1 << QW;
  localparam int MW = AMP_W - 1;
  localparam logic [MW-1:0] FULL = {MW{1'b1}};

  function automatic logic [MW-1:0] qmag(input int k);
    real r;
    r = real'((1 << MW) - 1) * $sin(1.5707963267948966 * real'(k) / real'(QN));
    return MW'($rtoi(r + 0.5));
  endfunction

  logic [MW-1:0] qtab [QN];
  for (genvar g = 0; g < QN; g++) begin : g_tab
    localparam logic [MW-1:0] V = qmag(g);
    assign qtab[g] = V;
  end

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;
  logic [ADDR_W-1:0] pa;
  logic [QW-1:0]    idx, sel;
  logic [MW-1:0]    mag_d, mag_q;
  logic             neg_q, v1;

  assign sum   = {1'b0, acc} + {1'b0, tune_word};
  assign pa    = ADDR_W'((acc + phase_ofs) >> (ACC_W - ADDR_W));
  assign idx   = pa[QW-1:0];
  assign sel   = pa[QW] ? -idx : idx;
  assign mag_d = (pa[QW] && idx == '0) ? FULL : qtab[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc          <= '0;
      wrap         <= 1'b0;
      mag_q        <= '0;
      neg_q        <= 1'b0;
      v1           <= 1'b0;
      sample_valid <= 1'b0;
      sample       <= '0;
    end else begin
      if (en) begin
        acc  <= sum[ACC_W-1:0];
        wrap <= sum[ACC_W];
      end else begin
        wrap <= 1'b0;
      end
      mag_q        <= mag_d;
      neg_q        <= pa[QW+1];
      v1           <= 1'b1;
      sample_valid <= v1;
      sample       <= neg_q ? -$signed({1'b0, mag_q}) : $signed({1'b0, mag_q});
    end
  end
endmodule

module nco_sine_chk #(
  parameter int ACC_W = 32,
  parameter int AMP_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic [ACC_W-1:0]        tune_word,
  input logic [ACC_W-1:0]        acc,
  input logic signed [AMP_W-1:0] sample,
  input logic                    sample_valid,
  input logic                    wrap
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc == '0 && sample == '0 && !sample_valid && !wrap));
  // R2
  acc_step_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> acc == $past(acc) + $past(tune_word));
  // R2
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(acc) && !wrap));
  // R7
  wrap_carry_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |-> ($past(en) && acc < $past(acc)));
  // R6
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> sample_valid);
  // R4
  no_min_code_chk: assert property (@(posedge clk) disable iff (rst)
    sample != {1'b1, {(AMP_W-1){1'b0}}});
endmodule

bind nco_sine nco_sine_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .tune_word(tune_word), .acc(acc),
  .sample(sample), .sample_valid(sample_valid), .wrap(wrap)
);

// File: tb/nco_sine_bench.sv
module nco_sine_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [31:0] tune_word = '0;
  logic [31:0] phase_ofs = '0;
  logic signed [15:0] sample;
  logic sample_valid, wrap;

  nco_sine u_nco_sine (
    .clk(clk), .rst(rst), .en(en), .tune_word(tune_word), .phase_ofs(phase_ofs),
    .sample(sample), .sample_valid(sample_valid), .wrap(wrap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int amp(input logic [11:0] p);
    int k, m;
    real r;
    k = int'(p[9:0]);
    if (p[10]) k = 1024 - k;
    r = 32767.0 * $sin(3.14159265358979323846 / 2.0 * real'(k) / 1024.0);
    m = $rtoi(r + 0.5);
    return p[11] ? -m : m;
  endfunction

  // reference model of register and pipeline
  logic [31:0] m_acc;
  logic [11:0] m_p1, m_p2;
  logic m_wrap, m_v1, m_v2;
  always @(posedge clk) begin
    if (rst) begin
      m_acc <= '0; m_p1 <= '0; m_p2 <= '0; m_wrap <= 1'b0; m_v1 <= 1'b0; m_v2 <= 1'b0;
    end else begin
      logic [32:0] s;
      logic [31:0] ph;
      s = {1'b0, m_acc} + {1'b0, tune_word};
      ph = m_acc + phase_ofs;
      if (en) begin
        m_acc  <= s[31:0];
        m_wrap <= s[32];
      end else begin
        m_wrap <= 1'b0;
      end
      m_p1 <= ph[31:20];
      m_p2 <= m_p1;
      m_v1 <= 1'b1;
      m_v2 <= m_v1;
    end
  end

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(sample == 16'(amp(m_p2)), req, sample, amp(m_p2));
      check(wrap == m_wrap, req, wrap, m_wrap);
      check(sample_valid == m_v2, req, sample_valid, m_v2);
    end
  endtask

  localparam int NV = 12;
  localparam logic [31:0] VOFS [NV] = '{
    32'h0000_0000, 32'h4000_0FFF, 32'h800F_FFFF, 32'hC000_0001,
    32'h2000_0000, 32'h6000_0000, 32'hA000_0000, 32'hE000_0000,
    32'h0010_0000, 32'hFFF0_0000, 32'h4010_0000, 32'h8010_0000};
  localparam int VEXP [NV] = '{
    0, 32767, 0, -32767,
    23170, 23170, -23170, -23170,
    50, -50, 32767, -50};

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sample == 0, "R1", sample, 0);
    check(sample_valid == 1'b0, "R1", sample_valid, 0);
    check(wrap == 1'b0, "R1", wrap, 0);

    tune_word = 32'h0123_4567;
    rst = 1'b0;
    @(negedge clk);
    check(sample_valid == 1'b0, "R6", sample_valid, 0);
    @(negedge clk);
    check(sample_valid == 1'b1, "R6", sample_valid, 1);
    check(sample == 0, "R5", sample, 0);

    // R4 / R3: register parked at zero, offset walks the circle
    for (int v = 0; v < NV; v++) begin
      phase_ofs = VOFS[v];
      repeat (3) @(negedge clk);
      check(sample == 16'(VEXP[v]), "R4", sample, VEXP[v]);
      check(wrap == 1'b0, "R2", wrap, 0);
    end

    phase_ofs = '0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(sample == 0 && !sample_valid && !wrap, "R1", sample, 0);
    rst = 1'b0;
    en = 1'b1;
    tune_word = 32'h0100_0000;
    run(200, "R5");
    tune_word = 32'h0008_0000;
    run(300, "R3");
    tune_word = 32'h4000_0000;
    run(40, "R7");
    tune_word = 32'hFFFF_FFFF;
    run(20, "R7");
    tune_word = 32'h0213_5A01;
    phase_ofs = 32'h8000_0000;
    run(30, "R8");
    phase_ofs = '0;
    run(30, "R8");
    en = 1'b0;
    run(20, "R2");
    en = 1'b1;
    tune_word = 32'h0AB1_2345;
    run(300, "R2");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule